// File: doc/BRIEF.md
# Virtual-Channel Credit Flow Controller

This block keeps the transmit-side credit accounts for a link that carries six message classes over three virtual networks. Two of the networks give each class its own buffer at the far end and are counted in whole packets, one counter per class and network. The third network is an adaptive one whose receive buffer is shared by every class, so it is counted in flits from a single common pool. Together the two dedicated networks and the shared one give eighteen virtual channels.

Each class presents one pending packet at a time: a valid bit, a length in flits and a choice of dedicated network to fall back on. In the same cycle the controller decides which classes can be sent and grants one of them in round-robin order. A packet uses the shared pool when the pool holds enough flits for all of it. Otherwise it uses one packet credit from its chosen dedicated channel. The receiver's returned credits arrive on a single return port, already taken from the inbound flow-control field. Credit limits are loaded with a one-cycle pulse when the link is brought up. A class keeps its packet on the port until it is granted, so packets within a class, including the ordered home class, go out in the order they were offered.

Top module: `vcf_credit_ctrl`

## Requirements
- R1: After reset and before the first load pulse, every credit count is zero, no request is granted and `cred_err` is 0.
- R2: In a cycle with `init_load` high, no grant is given. At the next edge every dedicated counter takes `init_ded`, the pool takes `init_pool`, these values become the limits, and `cred_err` clears.
- R3: Class codes are snoop 0, home 1, non-data response 2, data response 3, non-coherent standard 4 and non-coherent bypass 5. `gnt` is combinational from the current inputs and state. At most one bit of `gnt` is set, and only for a class whose request is valid with a nonzero length. A zero-length request is never granted.
- R4: When the pool holds at least the request length, a granted packet takes the shared network. `gnt_vn` is then 2 and the pool drops by the length at the next edge.
- R5: When the pool is short, a request is granted on the dedicated network chosen by its `req_vn1` bit (0 gives network 0, 1 gives network 1) if that channel's counter is nonzero. `gnt_vn` shows 0 or 1 and the counter drops by one. `gnt_vn` is 0 when nothing is granted.
- R6: A class whose pool fit and chosen dedicated counter are both exhausted is not granted.
- R7: The grant search starts at the class after the one granted last. After reset, class 0 has highest priority.
- R8: A return adds `ret_amt` at the next edge: to the pool when `ret_vn` is 2, or to channel (`ret_vn`, `ret_class`) when `ret_vn` is 0 or 1. A return and a debit on the same counter in one cycle both take effect.
- R9: If a return would lift a counter above its loaded limit, the counter stops at the limit and `cred_err` rises at the next edge. It stays high until the next load pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_load | input | 1 | Load credit limits pulse |
| init_ded | input | DED_W | Packet credits per dedicated channel |
| init_pool | input | POOL_W | Flit credits in shared pool |
| req_valid | input | NUM_CLASS | Per-class pending packet |
| req_len | input | NUM_CLASS*LEN_W | Per-class packet length in flits, class c at bits c*LEN_W |
| req_vn1 | input | NUM_CLASS | Per-class fallback network (0 or 1) |
| ret_valid | input | 1 | Credit return present |
| ret_vn | input | 2 | Return network: 0, 1, or 2 for pool |
| ret_class | input | CLS_W | Return class for dedicated networks |
| ret_amt | input | AMT_W | Number of credits returned |
| gnt | output | NUM_CLASS | One-hot grant |
| gnt_vn | output | 2 | Network used by grant |
| cred_err | output | 1 | Sticky credit overflow flag |

## Verification
The hardest state to reach is a channel being debited and credited in the same cycle, together with the moment the grant path falls back from the pool to a dedicated counter. The stimulus first drains the pool to below a packet length using large packets. It then drains single dedicated channels one packet at a time, so that fallback grants and exhaustion can be seen class by class. Next it issues a return to a channel in the same cycle that channel is granted, and counts how many further grants follow to show that both updates took effect. Overflow is reached by returning more credits than were loaded into an empty channel, then counting grants to confirm the clamp.

// File: rtl/vcf_pkg.sv
package vcf_pkg;
    localparam int NUM_MCLASS = 6;

    typedef enum logic [1:0] {
        VN_DED0   = 2'd0,
        VN_DED1   = 2'd1,
        VN_SHARED = 2'd2
    } vn_e;

    typedef enum logic [2:0] {
        MC_SNOOP = 3'd0,
        MC_HOME  = 3'd1,
        MC_NDR   = 3'd2,
        MC_DRS   = 3'd3,
        MC_NCS   = 3'd4,
        MC_NCB   = 3'd5
    } mclass_e;
endpackage

// File: rtl/vcf_rr_arb.sv
module vcf_rr_arb #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    found;

    always_comb begin
        st_d  = st_q;
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int k;
            k = (int'(st_q.ptr) + 1 + i) % N;
            if (!found && req[k]) begin
                found      = 1'b1;
                gnt[k]     = 1'b1;
                st_d.ptr   = PW'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.ptr <= PW'(N - 1);
        else        st_q     <= st_d;
    end

    AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R3

    AST_ARB_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R3
endmodule

// File: rtl/vcf_ded_bank.sv
module vcf_ded_bank #(
    parameter int NC   = 6,
    parameter int DW   = 3,
    parameter int AW   = 3,
    parameter int CLW  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_load,
    input  logic [DW-1:0]      init_val,
    input  logic               dbt_valid,
    input  logic               dbt_net,
    input  logic [CLW-1:0]     dbt_cls,
    input  logic               ret_valid,
    input  logic               ret_net,
    input  logic [CLW-1:0]     ret_cls,
    input  logic [AW-1:0]      ret_amt,
    output logic [2*NC*DW-1:0] cnt,
    output logic               ovf
);
    localparam int NCH = 2 * NC;
    localparam int SW  = ((DW > AW) ? DW : AW) + 1;

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] cnt;
        logic [DW-1:0]          lim;
    } bank_st_t;

    bank_st_t       st_d, st_q;
    logic [SW-1:0]  sum_w;
    logic           hit_dbt, hit_ret;

    always_comb begin
        st_d    = st_q;
        ovf     = 1'b0;
        sum_w   = '0;
        hit_dbt = 1'b0;
        hit_ret = 1'b0;
        if (init_load) begin
            st_d.lim = init_val;
            for (int ch = 0; ch < NCH; ch++) st_d.cnt[ch] = init_val;
        end else begin
            for (int ch = 0; ch < NCH; ch++) begin
                hit_dbt = dbt_valid && (ch == int'(dbt_net) * NC + int'(dbt_cls));
                hit_ret = ret_valid && (ch == int'(ret_net) * NC + int'(ret_cls));
                sum_w   = SW'(st_q.cnt[ch]) - (hit_dbt ? SW'(1) : SW'(0))
                        + (hit_ret ? SW'(ret_amt) : SW'(0));
                if (sum_w > SW'(st_q.lim)) begin
                    st_d.cnt[ch] = st_q.lim;
                    ovf          = 1'b1;
                end else begin
                    st_d.cnt[ch] = DW'(sum_w);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    for (genvar g = 0; g < NCH; g++) begin : g_lim_chk
        AST_DED_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[g] <= st_q.lim); // R9
    end

    AST_DEBIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dbt_valid |-> st_q.cnt[int'(dbt_net) * NC + int'(dbt_cls)] != '0); // R6
endmodule

// File: rtl/vcf_credit_ctrl.sv
module vcf_credit_ctrl
    import vcf_pkg::*;
#(
    parameter int NUM_CLASS = NUM_MCLASS,
    parameter int DED_W     = 3,
    parameter int POOL_W    = 5,
    parameter int LEN_W     = 3,
    parameter int AMT_W     = 3,
    localparam int CLS_W    = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       init_load,
    input  logic [DED_W-1:0]           init_ded,
    input  logic [POOL_W-1:0]          init_pool,
    input  logic [NUM_CLASS-1:0]       req_valid,
    input  logic [NUM_CLASS*LEN_W-1:0] req_len,
    input  logic [NUM_CLASS-1:0]       req_vn1,
    input  logic                       ret_valid,
    input  logic [1:0]                 ret_vn,
    input  logic [CLS_W-1:0]           ret_class,
    input  logic [AMT_W-1:0]           ret_amt,
    output logic [NUM_CLASS-1:0]       gnt,
    output logic [1:0]                 gnt_vn,
    output logic                       cred_err
);
    localparam int NC   = NUM_CLASS;
    localparam int MW0  = (POOL_W > LEN_W) ? POOL_W : LEN_W;
    localparam int SUMW = ((MW0 > AMT_W) ? MW0 : AMT_W) + 1;

    typedef struct packed {
        logic [POOL_W-1:0] pool;
        logic [POOL_W-1:0] lim;
        logic              err;
    } ctl_st_t;

    ctl_st_t                  st_d, st_q;
    logic [NC-1:0][LEN_W-1:0] len_v;
    logic [NC-1:0]            pool_fit, ded_ok, elig;
    logic [2*NC*DED_W-1:0]    ded_cnt;
    logic                     ded_ovf;
    logic [CLS_W-1:0]         gidx;
    logic                     any_gnt, take_pool;
    logic [LEN_W-1:0]         glen;
    logic                     bank_dbt, bank_ret;
    logic [SUMW-1:0]          pool_sum;

    // request decode and eligibility
    always_comb begin
        for (int c = 0; c < NC; c++) begin
            int ch;
            len_v[c]    = req_len[c*LEN_W +: LEN_W];
            ch          = (req_vn1[c] ? NC : 0) + c;
            ded_ok[c]   = ded_cnt[ch*DED_W +: DED_W] != '0;
            pool_fit[c] = SUMW'(st_q.pool) >= SUMW'(len_v[c]);
            elig[c]     = req_valid[c] && (len_v[c] != '0) && !init_load
                          && (pool_fit[c] || ded_ok[c]);
        end
    end

    vcf_rr_arb #(.N(NC)) i_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (elig),
        .gnt  (gnt)
    );

    // granted class decode
    always_comb begin
        gidx = '0;
        for (int c = 0; c < NC; c++) begin
            if (gnt[c]) gidx = CLS_W'(c);
        end
        any_gnt   = |gnt;
        take_pool = any_gnt && pool_fit[gidx];
        glen      = len_v[gidx];
        if (!any_gnt)       gnt_vn = VN_DED0;
        else if (take_pool) gnt_vn = VN_SHARED;
        else                gnt_vn = req_vn1[gidx] ? VN_DED1 : VN_DED0;
    end

    assign bank_dbt = any_gnt && !take_pool;
    assign bank_ret = ret_valid && (ret_vn == VN_DED0 || ret_vn == VN_DED1)
                      && (int'(ret_class) < NC);

    vcf_ded_bank #(.NC(NC), .DW(DED_W), .AW(AMT_W), .CLW(CLS_W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_load(init_load),
        .init_val (init_ded),
        .dbt_valid(bank_dbt),
        .dbt_net  (req_vn1[gidx]),
        .dbt_cls  (gidx),
        .ret_valid(bank_ret),
        .ret_net  (ret_vn[0]),
        .ret_cls  (ret_class),
        .ret_amt  (ret_amt),
        .cnt      (ded_cnt),
        .ovf      (ded_ovf)
    );

    // shared pool and error next state
    always_comb begin
        st_d     = st_q;
        pool_sum = SUMW'(st_q.pool)
                 - (take_pool ? SUMW'(glen) : SUMW'(0))
                 + ((ret_valid && ret_vn == VN_SHARED) ? SUMW'(ret_amt) : SUMW'(0));
        if (init_load) begin
            st_d.pool = init_pool;
            st_d.lim  = init_pool;
            st_d.err  = 1'b0;
        end else begin
            if (pool_sum > SUMW'(st_q.lim)) begin
                st_d.pool = st_q.lim;
                st_d.err  = 1'b1;
            end else begin
                st_d.pool = POOL_W'(pool_sum);
            end
            if (ded_ovf) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cred_err = st_q.err;

    AST_INIT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        init_load |-> gnt == '0); // R2

    AST_POOL_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pool <= st_q.lim); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_err && !init_load) |=> cred_err); // R9

    AST_SHARED_GRANT_DEBITS: assert property (@(posedge clk) disable iff (!rst_n)
        (any_gnt && gnt_vn == VN_SHARED && !(ret_valid && ret_vn == VN_SHARED))
        |=> st_q.pool < $past(st_q.pool)); // R4

    AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        any_gnt |-> glen != '0); // R3
endmodule

// File: tb/test_vcf_credit_ctrl.sv
module test_vcf_credit_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_load = 1'b0;
    logic [2:0]    init_ded = '0;
    logic [4:0]    init_pool = '0;
    logic [5:0]    req_valid = '0;
    logic [17:0]   req_len = '0;
    logic [5:0]    req_vn1 = '0;
    logic          ret_valid = 1'b0;
    logic [1:0]    ret_vn = '0;
    logic [2:0]    ret_class = '0;
    logic [2:0]    ret_amt = '0;
    logic [5:0]    gnt;
    logic [1:0]    gnt_vn;
    logic          cred_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcf_credit_ctrl i_vcf_credit_ctrl (
        .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_ded(init_ded),
        .init_pool(init_pool), .req_valid(req_valid), .req_len(req_len),
        .req_vn1(req_vn1), .ret_valid(ret_valid), .ret_vn(ret_vn),
        .ret_class(ret_class), .ret_amt(ret_amt), .gnt(gnt), .gnt_vn(gnt_vn),
        .cred_err(cred_err)
    );

    typedef struct packed {
        logic [5:0] rv;
        logic [2:0] len;
        logic [5:0] v1;
        logic       rt;
        logic [1:0] rvn;
        logic [2:0] rc;
        logic [2:0] ra;
        logic [5:0] eg;
        logic [1:0] ev;
        logic       ee;
        logic [3:0] tag;
    } vec_t;

    // After load: dedicated 2 per channel, pool 4 flits
    localparam vec_t VEC [28] = '{
        '{6'b000001,3'd3,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000001,2'd2,1'b0,4'd4}, // R4 pool 4->1
        '{6'b000011,3'd3,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000010,2'd0,1'b0,4'd7}, // R7 next after class0
        '{6'b000011,3'd3,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000001,2'd0,1'b0,4'd7}, // R7 wrap
        '{6'b000011,3'd3,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000010,2'd0,1'b0,4'd5}, // R5
        '{6'b000011,3'd3,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000001,2'd0,1'b0,4'd5}, // R5
        '{6'b000011,3'd3,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000000,2'd0,1'b0,4'd6}, // R6 exhausted
        '{6'b000011,3'd3,6'b000010,1'b0,2'd0,3'd0,3'd0,6'b000010,2'd1,1'b0,4'd5}, // R5 network 1
        '{6'b000001,3'd3,6'b000000,1'b1,2'd2,3'd0,3'd3,6'b000000,2'd0,1'b0,4'd8}, // R8 pool return
        '{6'b000001,3'd3,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000001,2'd2,1'b0,4'd8}, // R8 pool refilled
        '{6'b000000,3'd0,6'b000000,1'b1,2'd0,3'd1,3'd1,6'b000000,2'd0,1'b0,4'd8}, // R8 ded return
        '{6'b000010,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000010,2'd2,1'b0,4'd4}, // R4 prefer pool
        '{6'b000010,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000010,2'd0,1'b0,4'd8}, // R8 returned credit
        '{6'b000000,3'd0,6'b000000,1'b1,2'd0,3'd1,3'd3,6'b000000,2'd0,1'b0,4'd9}, // R9 overflow
        '{6'b000000,3'd0,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000000,2'd0,1'b1,4'd9}, // R9 flag
        '{6'b000010,3'd2,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000010,2'd0,1'b1,4'd9}, // R9 clamp 2
        '{6'b000010,3'd2,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000010,2'd0,1'b1,4'd9}, // R9
        '{6'b000010,3'd2,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000000,2'd0,1'b1,4'd9}, // R9 only two
        '{6'b000000,3'd0,6'b000000,1'b1,2'd2,3'd0,3'd7,6'b000000,2'd0,1'b1,4'd9}, // R9 pool clamp 4
        '{6'b111111,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000100,2'd2,1'b1,4'd7}, // R7
        '{6'b111111,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b001000,2'd2,1'b1,4'd7}, // R7
        '{6'b111111,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b010000,2'd2,1'b1,4'd7}, // R7
        '{6'b111111,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b100000,2'd2,1'b1,4'd9}, // R9 pool was 4
        '{6'b111111,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000100,2'd0,1'b1,4'd6}, // R6 skip empty
        '{6'b001000,3'd0,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000000,2'd0,1'b1,4'd3}, // R3 zero length
        '{6'b001000,3'd1,6'b000000,1'b1,2'd0,3'd3,3'd1,6'b001000,2'd0,1'b1,4'd8}, // R8 same-cycle
        '{6'b001000,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b001000,2'd0,1'b1,4'd8}, // R8
        '{6'b001000,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b001000,2'd0,1'b1,4'd8}, // R8
        '{6'b001000,3'd1,6'b000000,1'b0,2'd0,3'd0,3'd0,6'b000000,2'd0,1'b1,4'd8}  // R8 now empty
    };

    task automatic chk(input string rq, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        init_load = 1'b0;
        req_valid = '0;
        req_len   = '0;
        req_vn1   = '0;
        ret_valid = 1'b0;
        ret_vn    = '0;
        ret_class = '0;
        ret_amt   = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        $display("FAIL R3 watchdog actual running expected finished");
        checks++;
        errors++;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, nothing grantable before load
        @(negedge clk);
        req_valid = 6'b000001;
        req_len   = {6{3'd1}};
        #1;
        chk("R1", "gnt", 8'(gnt), 8'h00);
        chk("R1", "err", 8'(cred_err), 8'h00);

        // R2: load cycle grants nothing
        @(negedge clk);
        idle_inputs();
        init_load = 1'b1;
        init_ded  = 3'd2;
        init_pool = 5'd4;
        req_valid = 6'b000001;
        req_len   = {6{3'd1}};
        #1;
        chk("R2", "gnt during load", 8'(gnt), 8'h00);

        for (int i = 0; i < 28; i++) begin
            @(negedge clk);
            idle_inputs();
            req_valid = VEC[i].rv;
            req_len   = {6{VEC[i].len}};
            req_vn1   = VEC[i].v1;
            ret_valid = VEC[i].rt;
            ret_vn    = VEC[i].rvn;
            ret_class = VEC[i].rc;
            ret_amt   = VEC[i].ra;
            #1;
            checks++;
            if (gnt !== VEC[i].eg || gnt_vn !== VEC[i].ev || cred_err !== VEC[i].ee) begin
                errors++;
                $display("FAIL R%0d vector %0d actual gnt %b vn %0d err %b expected gnt %b vn %0d err %b",
                         VEC[i].tag, i, gnt, gnt_vn, cred_err, VEC[i].eg, VEC[i].ev, VEC[i].ee);
            end
        end

        // R2: reload with new limits clears error
        @(negedge clk);
        idle_inputs();
        init_load = 1'b1;
        init_ded  = 3'd1;
        init_pool = 5'd2;
        req_valid = 6'b010000;
        req_len   = {6{3'd2}};
        #1;
        chk("R2", "gnt during reload", 8'(gnt), 8'h00);

        @(negedge clk);
        init_load = 1'b0;
        #1;
        chk("R2", "err cleared", 8'(cred_err), 8'h00);
        chk("R4", "gnt pool fit", 8'(gnt), 8'h10);
        chk("R4", "vn shared", 8'(gnt_vn), 8'h02);

        @(negedge clk);
        #1;
        chk("R5", "gnt fallback", 8'(gnt), 8'h10);
        chk("R5", "vn zero", 8'(gnt_vn), 8'h00);

        @(negedge clk);
        #1;
        chk("R6", "gnt exhausted", 8'(gnt), 8'h00);
        chk("R5", "vn idle", 8'(gnt_vn), 8'h00);

        @(negedge clk);
        idle_inputs();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule